// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers up to 32 asynchronous interrupt lines from outside the chip and turns them into one interrupt request to the processor. Each line passes through a synchroniser. A per-line detector then watches it for a rising edge, a falling edge, a high level or a low level, as software chooses. Detected events set bits in a pending register. A mask register gates those bits, and the combined output is raised while any pending bit is unmasked. Software reads the pending register to find out which lines need service. It then acknowledges each line by writing ones to a clear register.

The block sits on a plain word-addressed register bus with a three-bit word offset. Writes take effect on the clock edge where the write enable is sampled. Read data appears one clock after the read enable is sampled and holds until the next read. The mask has a set port and a clear port of its own, so no read-modify-write is needed. Lines above the implemented count `N_LINES` do not exist: their bits read as zero in every register. Software can therefore count the lines by writing all ones to the sense register and reading it back.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset every readable register (mask view, pending, sense, edge polarity, level polarity) reads zero and `irq` is low.
- R2: Word offsets: 0 mask set, 1 mask clear, 2 mask view, 3 pending, 4 acknowledge, 5 sense, 6 edge polarity, 7 level polarity. Offsets 0, 1 and 4 are write-only and read as zero.
- R3: With sense bit 0 (edge) and edge-polarity bit 1, a rising transition on the line sets its pending bit, and a falling transition does not.
- R4: With sense bit 0 and edge-polarity bit 0, a falling transition sets the pending bit, and a rising transition does not.
- R5: With sense bit 1 (level) and level-polarity bit 1, a high line sets the pending bit, and a low line does not.
- R6: With sense bit 1 and level-polarity bit 0, a low line sets the pending bit, and a high line does not.
- R7: Writing offset 0 sets each mask bit whose write-data bit is 1. Mask bits written with 0 keep their value.
- R8: Writing offset 1 clears each mask bit whose write-data bit is 1. The mask is read back at offset 2.
- R9: Writing offset 4 clears each pending bit whose write-data bit is 1. Zero bits leave pending unchanged.
- R10: Pending bits are set whatever the mask holds. `irq` is high one clock after pending AND mask is non-zero, and low otherwise.
- R11: In level mode, a pending bit that is acknowledged while its level is still active is set again and reads as 1.
- R12: When an edge event and an acknowledge of the same bit land in the same clock, the bit stays set.
- R13: Only bits 0 to N_LINES-1 are storable. After all ones are written, the sense and polarity registers read 2^N_LINES-1, and read data above bit N_LINES-1 is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Word offset of the register |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | DATA_W | Registered read data |
| lines | input | N_LINES | Asynchronous external interrupt lines |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bench goes after the acknowledge race. An acknowledge is placed in the same clock as a fresh edge event. A design that gives the clear priority would lose that interrupt, and the pending bit would read zero. The bench also acknowledges a level line while the level is still active. A design that treats level events like edges would leave the bit clear even though the source still asks for service. Other cases are writes with zero bits to the mask and acknowledge ports, the transitions of the wrong direction on edge lines, and a set pending bit whose mask bit is off. In each of these cases a wrong design would change state or raise `irq`. Last, the bench writes all ones to the configuration registers and checks that bits above the line count read zero, so that a design storing phantom lines would report the wrong line count.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK_SET  = 3'd0,
    SEL_MASK_CLR  = 3'd1,
    SEL_MASK_VIEW = 3'd2,
    SEL_PENDING   = 3'd3,
    SEL_ACK       = 3'd4,
    SEL_SENSE     = 3'd5,
    SEL_EDGE_POL  = 3'd6,
    SEL_LVL_POL   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int N_LINES = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] async_in,
  output logic [N_LINES-1:0] sync_out
);
  logic [N_LINES-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] sampled,
  input  logic [N_LINES-1:0] sense,     // 1 = level, 0 = edge
  input  logic [N_LINES-1:0] edge_pol,  // 1 = rising, 0 = falling
  input  logic [N_LINES-1:0] lvl_pol,   // 1 = high, 0 = low
  output logic [N_LINES-1:0] event_o
);
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else prev_q <= sampled;
  end

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic rise, fall;
      assign rise = sampled[i] & ~prev_q[i];
      assign fall = ~sampled[i] & prev_q[i];
      always_comb begin
        if (sense[i]) event_o[i] = (sampled[i] == lvl_pol[i]);
        else if (edge_pol[i]) event_o[i] = rise;
        else event_o[i] = fall;
      end
    end
  endgenerate

  // R3/R4: an edge-mode line never flags an event while its sample is steady
  a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
    ((event_o & ~sense) != '0) |-> ((sampled & ~sense) != (prev_q & ~sense)));
endmodule

// File: rtl/extirq_regfile.sv
module extirq_regfile
  import extirq_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wbits,
  input  logic               we,
  input  logic               re,
  input  logic [N_LINES-1:0] event_i,
  output logic [N_LINES-1:0] sense_q,
  output logic [N_LINES-1:0] edge_pol_q,
  output logic [N_LINES-1:0] lvl_pol_q,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  logic [N_LINES-1:0] mask_q, pend_q, ack_bits;

  function automatic logic [DATA_W-1:0] widen(input logic [N_LINES-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[N_LINES-1:0] = v;
    return r;
  endfunction

  assign ack_bits = (we && addr == SEL_ACK) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      sense_q    <= '0;
      edge_pol_q <= '0;
      lvl_pol_q  <= '0;
    end else if (we) begin
      case (addr)
        SEL_MASK_SET: mask_q     <= mask_q | wbits;
        SEL_MASK_CLR: mask_q     <= mask_q & ~wbits;
        SEL_SENSE:    sense_q    <= wbits;
        SEL_EDGE_POL: edge_pol_q <= wbits;
        SEL_LVL_POL:  lvl_pol_q  <= wbits;
        default: ;
      endcase
    end
  end

  // new events take priority over an acknowledge of the same bit
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else pend_q <= (pend_q & ~ack_bits) | event_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= |(pend_q & mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) begin
      case (addr)
        SEL_MASK_VIEW: rdata <= widen(mask_q);
        SEL_PENDING:   rdata <= widen(pend_q);
        SEL_SENSE:     rdata <= widen(sense_q);
        SEL_EDGE_POL:  rdata <= widen(edge_pol_q);
        SEL_LVL_POL:   rdata <= widen(lvl_pol_q);
        default:       rdata <= '0;
      endcase
    end
  end

  a_r7_mask_set: assert property (@(posedge clk) disable iff (rst)
    (we && addr == SEL_MASK_SET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

  a_r8_mask_clear: assert property (@(posedge clk) disable iff (rst)
    (we && addr == SEL_MASK_CLR) |=> ((mask_q & $past(wbits)) == '0));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (we && addr == SEL_ACK) |=> ((pend_q & $past(wbits) & ~$past(event_i)) == '0));

  a_r12_event_wins: assert property (@(posedge clk) disable iff (rst)
    (event_i != '0) |=> ((pend_q & $past(event_i)) == $past(event_i)));

  a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0 && $past(mask_q) == '0) |-> !irq);

  generate
    if (N_LINES < DATA_W) begin : g_upper
      a_r13_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:N_LINES] == '0);
    end
  endgenerate
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               we,
  input  logic               re,
  output logic [DATA_W-1:0]  rdata,
  input  logic [N_LINES-1:0] lines,
  output logic               irq
);
  logic [N_LINES-1:0] sampled, events, sense, edge_pol, lvl_pol;

  generate
    if (N_LINES < DATA_W) begin : g_spare
      logic unused_upper;
      assign unused_upper = ^wdata[DATA_W-1:N_LINES];
    end
  endgenerate

  extirq_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(lines), .sync_out(sampled)
  );

  extirq_detect #(.N_LINES(N_LINES)) u_detect (
    .clk(clk), .rst(rst), .sampled(sampled), .sense(sense),
    .edge_pol(edge_pol), .lvl_pol(lvl_pol), .event_o(events)
  );

  extirq_regfile #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wbits(wdata[N_LINES-1:0]),
    .we(we), .re(re), .event_i(events), .sense_q(sense),
    .edge_pol_q(edge_pol), .lvl_pol_q(lvl_pol), .rdata(rdata), .irq(irq)
  );
endmodule

// File: tb/extirq_ctrl_test.sv
`timescale 1ns/1ps
module extirq_ctrl_test;
  localparam int N = 8;
  localparam int DW = 32;

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, re = 1'b0, rd_flag = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0] lines = '0;
  logic irq;
  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  extirq_ctrl #(.N_LINES(N), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .lines(lines), .irq(irq)
  );

  always @(posedge clk) rd_flag <= re;

  // monitor: pops expected read data once the registered result is out
  always @(negedge clk) begin
    if (rd_flag && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk); addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk); lines[i] = v;
    idle(5);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(3'd2, 32'h0, "R1 mask"); rd(3'd3, 32'h0, "R1 pending");
    rd(3'd5, 32'h0, "R1 sense"); rd(3'd6, 32'h0, "R1 edge pol");
    rd(3'd7, 32'h0, "R1 level pol");
    // R13 line count discovery; all-level active-low with pins low (R6)
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, 32'h0000_00FF, "R13 sense readback");
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, 32'h0000_00FF, "R13 edge readback");
    rd(3'd3, 32'h0000_00FF, "R6 active-low all lines");
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, 32'h0000_00FF, "R13 level readback");
    wr(3'd5, 0); wr(3'd6, 0); wr(3'd7, 0); wr(3'd4, 32'hFF);
    rd(3'd3, 32'h0, "R9 ack all");
    // R7 / R8 mask ports
    wr(3'd0, 32'h05); rd(3'd2, 32'h05, "R7 set mask");
    wr(3'd0, 32'h02); rd(3'd2, 32'h07, "R7 zero bits keep");
    wr(3'd1, 32'h04); rd(3'd2, 32'h03, "R8 clear mask");
    chk_irq(1'b0, "R10 no pending");
    // R3 rising edge on lines 0 and 3
    wr(3'd6, 32'h09);
    pin(0, 1'b1); rd(3'd3, 32'h01, "R3 rising sets");
    chk_irq(1'b1, "R10 masked-in pending");
    wr(3'd4, 32'h02); rd(3'd3, 32'h01, "R9 zero bit no effect");
    wr(3'd4, 32'h01); rd(3'd3, 32'h00, "R9 ack clears");
    idle(2); chk_irq(1'b0, "R10 irq drops");
    // R4 falling edge on line 1
    pin(1, 1'b1); rd(3'd3, 32'h00, "R4 rising ignored");
    pin(1, 1'b0); rd(3'd3, 32'h02, "R4 falling sets");
    chk_irq(1'b1, "R4 irq");
    wr(3'd4, 32'h02);
    // R10 pending without mask
    pin(3, 1'b1); rd(3'd3, 32'h08, "R10 pending despite mask");
    chk_irq(1'b0, "R10 masked out");
    wr(3'd0, 32'h08); idle(2); chk_irq(1'b1, "R10 unmask raises");
    wr(3'd4, 32'h08); wr(3'd1, 32'h08);
    pin(3, 1'b0); rd(3'd3, 32'h00, "R3 falling ignored");
    // R5 / R11 level high on line 4
    wr(3'd7, 32'h10); wr(3'd5, 32'h10);
    rd(3'd3, 32'h00, "R5 inactive low");
    pin(4, 1'b1); rd(3'd3, 32'h10, "R5 high sets");
    wr(3'd4, 32'h10); rd(3'd3, 32'h10, "R11 reasserts");
    pin(4, 1'b0); wr(3'd4, 32'h10); rd(3'd3, 32'h00, "R11 clears when idle");
    // R6 level low on line 5
    pin(5, 1'b1); wr(3'd5, 32'h30);
    rd(3'd3, 32'h00, "R6 inactive high");
    pin(5, 1'b0); rd(3'd3, 32'h20, "R6 low sets");
    pin(5, 1'b1); wr(3'd4, 32'h20); rd(3'd3, 32'h00, "R6 ack");
    // R12 edge event and ack in the same clock
    pin(0, 1'b0); rd(3'd3, 32'h00, "R3 line0 fall ignored");
    @(negedge clk); lines[0] = 1'b1;
    @(negedge clk);
    wr(3'd4, 32'h01); rd(3'd3, 32'h01, "R12 event wins");
    wr(3'd4, 32'h01); rd(3'd3, 32'h00, "R9 later ack");
    // R2 write-only offsets and final map
    rd(3'd0, 32'h0, "R2 offset 0 reads zero");
    rd(3'd1, 32'h0, "R2 offset 1 reads zero");
    rd(3'd4, 32'h0, "R2 offset 4 reads zero");
    rd(3'd2, 32'h03, "R2 mask view"); rd(3'd5, 32'h30, "R2 sense");
    rd(3'd6, 32'h09, "R2 edge pol"); rd(3'd7, 32'h10, "R2 level pol");
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule